// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block connects the serial bit stream of a UART framer to an infrared transceiver. On the transmit side, each zero bit from the framer becomes one short active-high light pulse on `sir_out`. A one bit produces no pulse. The pulse width comes from one of two modes. In narrow mode it is three 16x ticks, which is 3/16 of a bit. In low-power mode it is three periods of a separate reference tick, whatever the bit rate is. On the receive side, active-low pulses arriving on `sir_in_n` are synchronised and turned back into low bits of a UART-style stream on `rx_bit`.

The path is active only when both the global enable and the infrared enable are set. While it is active, the wired UART transmit pin is held in the marking (high) state and the wired receive pin is ignored. While it is inactive, the wired pins pass straight through and the infrared pins do nothing. Two loopback paths exist. The first sends the wired transmit level back to `rx_bit`. The second feeds the encoder pulse, inverted to the transceiver's active-low sense, into the decoder in place of `sir_in_n`.

A 4-bit phase counter splits time into 16-tick bit windows. While inactive it rests at phase 15, so the first `tick16` after activation opens window 0. The encoder FSM has the states MARK (no pulse), NARROW (3-tick pulse) and FIXED (low-power pulse). A window-opening tick with `tx_bit` low moves it from any state to NARROW or FIXED, depending on `lp_sel`. A window-opening tick with `tx_bit` high moves it to MARK. NARROW returns to MARK on the tick that leaves phase 2. FIXED returns to MARK on the third `lp_tick`. Losing the enable sends the FSM to MARK. The decoder FSM has the states WAIT (`rx_bit` high) and SPACE (`rx_bit` low). WAIT moves to SPACE on a tick where the synchronised pulse is present. SPACE returns to WAIT on its 16th tick unless a pulse is present then, in which case it stays in SPACE for another bit. Losing the enable also sends it to WAIT.

Top module: `sir_codec`

## Requirements
- R1: With the path active and `lp_sel`=0, a `tx_bit` of 0 sampled at the window-opening tick (phase 15 to 0) makes `sir_out` rise at that tick. It stays high for exactly three `tick16` intervals, which are phases 0, 1 and 2. A `tx_bit` of 1 gives no pulse.
- R2: With `lp_sel`=1 at the window-opening tick, the pulse ends on the third `lp_tick` after its start. It lasts between 2L+1 and 3L clocks for an `lp_tick` period of L clocks, at any `tick16` rate.
- R3: When `uart_en`=0 or `sir_en`=0, the following hold. `sir_out` stays low from the next cycle on. `uart_txd` equals `tx_bit`. `rx_bit` equals `uart_rxd` when loopback is off. Activity on `sir_in_n` has no effect.
- R4: When both enables are 1, `uart_txd` is held at 1 and `uart_rxd` has no effect on `rx_bit`.
- R5: The decoder accepts a pulse when the synchronised active-low `sir_in_n` is low at a `tick16`. It then drives `rx_bit` low for exactly 16 `tick16` intervals, starting at that tick. A glitch that lies between two ticks leaves `rx_bit` high.
- R6: If a pulse is present at the 16th tick of a low period, `rx_bit` stays low for another 16 ticks. Two back-to-back zeros therefore give one low run of 32 ticks.
- R7: With `loop_en`=1 and `sir_test`=1, the decoder input is the encoder pulse inverted to active-low, and `sir_in_n` is ignored. A zero sent at window w appears on `rx_bit` from phase 1 of window w to phase 1 of window w+1.
- R8: With `loop_en`=1 and `sir_test`=0, `rx_bit` equals the `uart_txd` level. That level is `tx_bit` when the path is inactive and 1 when it is active.
- R9: After reset, `sir_out` is 0, both FSMs are idle, and `rx_bit` and `uart_txd` follow the pass-through rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_en | input | 1 | Global UART enable |
| sir_en | input | 1 | Infrared path enable (effective only with `uart_en`) |
| lp_sel | input | 1 | 1 selects the low-power pulse width |
| loop_en | input | 1 | Loopback enable |
| sir_test | input | 1 | With `loop_en`, selects the infrared loopback path |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| lp_tick | input | 1 | One-cycle strobe of the low-power reference |
| tx_bit | input | 1 | Serial bit from the framer |
| uart_rxd | input | 1 | Wired receive pin |
| sir_in_n | input | 1 | Transceiver receive, active-low pulses |
| uart_txd | output | 1 | Wired transmit pin |
| sir_out | output | 1 | Transceiver drive, active-high pulses |
| rx_bit | output | 1 | Serial bit to the framer |

## Verification
The bench builds the block with its default parameters: 16 phases, a 3-tick pulse, 3 low-power periods and 2 synchroniser stages. Because `tick16` and `lp_tick` come from bench-side dividers, the tick period can change at run time. A sweep sends all sixteen 4-bit patterns through the infrared loopback in both width modes, at two `tick16` periods. This exercises back-to-back zeros, isolated zeros and the claim that low-power width does not depend on bit rate. Directed passes drive external pulses, sub-tick glitches and the enable and loopback combinations.

// File: rtl/sir_pkg.sv
package sir_pkg;

    typedef enum logic [1:0] {
        ENC_MARK   = 2'd0,
        ENC_NARROW = 2'd1,
        ENC_FIXED  = 2'd2
    } enc_state_t;

    typedef enum logic {
        DEC_WAIT  = 1'b0,
        DEC_SPACE = 1'b1
    } dec_state_t;

endpackage

// File: rtl/sir_bit_phase.sv
module sir_bit_phase #(
    parameter int PHASES = 16,
    parameter int PW     = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          tick16,
    output logic [PW-1:0] phase,
    output logic          win_open
);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    // Parked on the last phase while inactive: the first tick opens window 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= LAST;
        end else if (!active) begin
            phase <= LAST;
        end else if (tick16) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    always_comb begin
        win_open = active && tick16 && (phase == LAST);
    end

endmodule

// File: rtl/sir_pulse_enc.sv
module sir_pulse_enc
    import sir_pkg::*;
#(
    parameter int PHASES      = 16,
    parameter int PULSE_TICKS = 3,
    parameter int LP_PERIODS  = 3,
    parameter int PW          = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          tick16,
    input  logic          lp_tick,
    input  logic          win_open,
    input  logic [PW-1:0] phase,
    input  logic          tx_bit,
    input  logic          lp_sel,
    output logic          pulse
);
    localparam int            CW       = $clog2(LP_PERIODS + 1);
    localparam logic [PW-1:0] END_PH   = PW'(PULSE_TICKS - 1);
    localparam logic [CW-1:0] LP_LAST  = CW'(LP_PERIODS - 1);

    enc_state_t    state, state_nxt;
    logic [CW-1:0] lp_cnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ENC_MARK;
        end else begin
            state <= state_nxt;
        end
    end

    // Low-power period counter, restarted at every window opening
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lp_cnt <= '0;
        end else if (state != ENC_FIXED || win_open) begin
            lp_cnt <= '0;
        end else if (lp_tick) begin
            lp_cnt <= lp_cnt + 1'b1;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        if (!active) begin
            state_nxt = ENC_MARK;
        end else if (win_open) begin
            if (tx_bit)      state_nxt = ENC_MARK;
            else if (lp_sel) state_nxt = ENC_FIXED;
            else             state_nxt = ENC_NARROW;
        end else begin
            unique case (state)
                ENC_MARK:   state_nxt = ENC_MARK;
                ENC_NARROW: if (tick16 && phase == END_PH)   state_nxt = ENC_MARK;
                ENC_FIXED:  if (lp_tick && lp_cnt == LP_LAST) state_nxt = ENC_MARK;
                default:    state_nxt = ENC_MARK;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ENC_NARROW, ENC_FIXED: pulse = 1'b1;
            default:               pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/sir_pulse_dec.sv
module sir_pulse_dec
    import sir_pkg::*;
#(
    parameter int PHASES      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PW          = $clog2(PHASES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick16,
    input  logic pin_n,
    output logic rx
);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   seen;
    dec_state_t             state, state_nxt;
    logic [PW-1:0]          cnt;

    // Synchroniser chain on the active-high form of the pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ~pin_n};
        end
    end

    always_comb begin
        seen = sync_q[SYNC_STAGES-1];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DEC_WAIT;
        end else begin
            state <= state_nxt;
        end
    end

    // Tick count within the low period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state_nxt != DEC_SPACE) begin
            cnt <= '0;
        end else if (state == DEC_SPACE && tick16) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        if (!active) begin
            state_nxt = DEC_WAIT;
        end else begin
            unique case (state)
                DEC_WAIT:  if (tick16 && seen) state_nxt = DEC_SPACE;
                DEC_SPACE: if (tick16 && cnt == LAST && !seen) state_nxt = DEC_WAIT;
                default:   state_nxt = DEC_WAIT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            DEC_SPACE: rx = 1'b0;
            default:   rx = 1'b1;
        endcase
    end

endmodule

// File: rtl/sir_codec.sv
module sir_codec #(
    parameter int PHASES      = 16,
    parameter int PULSE_TICKS = 3,
    parameter int LP_PERIODS  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uart_en,
    input  logic sir_en,
    input  logic lp_sel,
    input  logic loop_en,
    input  logic sir_test,
    input  logic tick16,
    input  logic lp_tick,
    input  logic tx_bit,
    input  logic uart_rxd,
    input  logic sir_in_n,
    output logic uart_txd,
    output logic sir_out,
    output logic rx_bit
);
    localparam int PW = $clog2(PHASES);

    logic          active;
    logic          loop_ir;
    logic          loop_wire;
    logic [PW-1:0] phase;
    logic          win_open;
    logic          enc_pulse;
    logic          dec_pin_n;
    logic          dec_rx;

    always_comb begin
        active    = uart_en && sir_en;
        loop_ir   = loop_en && sir_test;
        loop_wire = loop_en && !sir_test;
    end

    sir_bit_phase #(
        .PHASES (PHASES),
        .PW     (PW)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick16   (tick16),
        .phase    (phase),
        .win_open (win_open)
    );

    sir_pulse_enc #(
        .PHASES      (PHASES),
        .PULSE_TICKS (PULSE_TICKS),
        .LP_PERIODS  (LP_PERIODS),
        .PW          (PW)
    ) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick16   (tick16),
        .lp_tick  (lp_tick),
        .win_open (win_open),
        .phase    (phase),
        .tx_bit   (tx_bit),
        .lp_sel   (lp_sel),
        .pulse    (enc_pulse)
    );

    // Infrared loopback: encoder pulse inverted to the transceiver's low-active sense
    always_comb begin
        dec_pin_n = loop_ir ? ~enc_pulse : sir_in_n;
    end

    sir_pulse_dec #(
        .PHASES      (PHASES),
        .SYNC_STAGES (SYNC_STAGES),
        .PW          (PW)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .tick16 (tick16),
        .pin_n  (dec_pin_n),
        .rx     (dec_rx)
    );

    always_comb begin
        sir_out  = enc_pulse;
        uart_txd = active ? 1'b1 : tx_bit;
        if (loop_wire)   rx_bit = uart_txd;
        else if (active) rx_bit = dec_rx;
        else             rx_bit = uart_rxd;
    end

endmodule

// File: rtl/sir_codec_chk.sv
module sir_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic uart_en,
    input logic sir_en,
    input logic lp_sel,
    input logic loop_en,
    input logic tick16,
    input logic lp_tick,
    input logic tx_bit,
    input logic sir_out,
    input logic rx_bit
);
    logic [2:0] tk_hi;
    logic [2:0] lp_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tk_hi <= '0;
            lp_hi <= '0;
        end else if (!sir_out) begin
            tk_hi <= '0;
            lp_hi <= '0;
        end else begin
            if (tick16 && tk_hi != 3'd7)  tk_hi <= tk_hi + 1'b1;
            if (lp_tick && lp_hi != 3'd7) lp_hi <= lp_hi + 1'b1;
        end
    end

    // R1: a pulse only starts on a tick, for a zero bit
    a_r1_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sir_out) |-> ($past(tick16) && !$past(tx_bit)));

    // R1: narrow pulse never outlives three ticks
    a_r1_narrow_width: assert property (@(posedge clk) disable iff (!rst_n)
        (sir_out && !lp_sel) |-> (tk_hi < 3'd3));

    // R2: low-power pulse never outlives three reference periods
    a_r2_fixed_width: assert property (@(posedge clk) disable iff (!rst_n)
        (sir_out && lp_sel) |-> (lp_hi < 3'd3));

    // R3: output quiet once the path is inactive
    a_r3_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(uart_en && sir_en) |=> !sir_out);

    // R5: decoded low periods begin on a tick
    a_r5_space_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_en && sir_en && !loop_en && $past(uart_en && sir_en && !loop_en)
         && $fell(rx_bit)) |-> $past(tick16));

endmodule

bind sir_codec sir_codec_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .uart_en (uart_en),
    .sir_en  (sir_en),
    .lp_sel  (lp_sel),
    .loop_en (loop_en),
    .tick16  (tick16),
    .lp_tick (lp_tick),
    .tx_bit  (tx_bit),
    .sir_out (sir_out),
    .rx_bit  (rx_bit)
);

// File: tb/sir_codec_bench.sv
module sir_codec_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LPDIV      = 5;

    logic clk = 0;
    logic rst_n = 0;
    logic uart_en = 0, sir_en = 0, lp_sel = 0, loop_en = 0, sir_test = 0;
    logic tick16 = 0, lp_tick = 0;
    logic tx_bit = 1, uart_rxd = 1, sir_in_n = 1;
    logic uart_txd, sir_out, rx_bit;

    int total = 0, bad = 0;
    int div = 4;
    int tc = 0, lc = 0;
    int hi_run = 0, n_pulse = 0, pmin = 1000000, pmax = 0;
    int lo_run = 0, n_low = 0, last_lo = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sir_codec u_sir_codec (
        .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .sir_en(sir_en),
        .lp_sel(lp_sel), .loop_en(loop_en), .sir_test(sir_test),
        .tick16(tick16), .lp_tick(lp_tick), .tx_bit(tx_bit),
        .uart_rxd(uart_rxd), .sir_in_n(sir_in_n),
        .uart_txd(uart_txd), .sir_out(sir_out), .rx_bit(rx_bit)
    );

    // Tick dividers and output monitors, all on the falling edge
    always @(negedge clk) begin
        if (tc >= div - 1) begin tick16 <= 1; tc <= 0; end
        else begin tick16 <= 0; tc <= tc + 1; end
        if (lc >= LPDIV - 1) begin lp_tick <= 1; lc <= 0; end
        else begin lp_tick <= 0; lc <= lc + 1; end
        if (rst_n) begin
            if (sir_out) hi_run++;
            else if (hi_run > 0) begin
                n_pulse++;
                if (hi_run < pmin) pmin = hi_run;
                if (hi_run > pmax) pmax = hi_run;
                hi_run = 0;
            end
            if (!rx_bit) lo_run++;
            else if (lo_run > 0) begin
                n_low++; last_lo = lo_run; lo_run = 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_strobe();
        do @(posedge clk); while (!tick16);
        @(negedge clk);
    endtask

    task automatic strobes(input int n);
        for (int k = 0; k < n; k++) wait_strobe();
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // R1, R2, R7: round trip of a 4-bit pattern through the infrared loopback
    task automatic run_pattern(input logic lpm, input int d, input logic [3:0] pat);
        int np0, zeros;
        logic [3:0] got;
        sir_en = 0; div = d; cycles(2 * d);
        lp_sel = lpm; loop_en = 1; sir_test = 1; sir_in_n = 0;
        pmin = 1000000; pmax = 0; np0 = n_pulse;
        zeros = 4 - $countones(pat);
        got = '0;
        sir_en = 1;
        for (int i = 0; i < 4; i++) begin
            tx_bit = pat[i];
            wait_strobe();
            strobes(8);
            got[i] = rx_bit;
            strobes(7);
        end
        tx_bit = 1;
        strobes(16);
        check("R7 idle high after pattern", int'(rx_bit), 1);
        check($sformatf("R7 pattern lp=%0d div=%0d", lpm, d), int'(got), int'(pat));
        check($sformatf("R1 pulse count pat=%0d", pat), n_pulse - np0, zeros);
        if (zeros > 0) begin
            if (!lpm) begin
                check($sformatf("R1 narrow min div=%0d", d), pmin, 3 * d);
                check($sformatf("R1 narrow max div=%0d", d), pmax, 3 * d);
            end else begin
                check_rng($sformatf("R2 fixed min div=%0d", d), pmin, 2 * LPDIV + 1, 3 * LPDIV);
                check_rng($sformatf("R2 fixed max div=%0d", d), pmax, 2 * LPDIV + 1, 3 * LPDIV);
            end
        end
        sir_en = 0; sir_in_n = 1; loop_en = 0; sir_test = 0; lp_sel = 0;
        cycles(4);
    endtask

    initial begin
        int np0, nl0;
        cycles(3);
        rst_n = 1;
        cycles(2);
        // R9 reset state
        check("R9 sir_out after reset", int'(sir_out), 0);
        check("R9 uart_txd after reset", int'(uart_txd), 1);
        check("R9 rx_bit after reset", int'(rx_bit), 1);

        // R3: infrared path off, wired pins pass through
        uart_en = 1; sir_en = 0; tx_bit = 0;
        np0 = n_pulse; nl0 = n_low;
        sir_in_n = 0; cycles(40); sir_in_n = 1; cycles(40);
        check("R3 txd follows tx_bit", int'(uart_txd), 0);
        check("R3 no pulse while off", n_pulse - np0, 0);
        check("R3 sir_in ignored while off", n_low - nl0, 0);
        uart_rxd = 0; cycles(2);
        check("R3 rxd passes through", int'(rx_bit), 0);
        uart_rxd = 1;
        uart_en = 0; sir_en = 1; np0 = n_pulse; cycles(100);
        check("R3 sir_en without uart_en txd", int'(uart_txd), 0);
        check("R3 sir_en without uart_en pulses", n_pulse - np0, 0);
        tx_bit = 1; sir_en = 0; uart_en = 1; cycles(4);

        // R8: wired loopback
        loop_en = 1; sir_test = 0; tx_bit = 0; cycles(2);
        check("R8 wired loop low", int'(rx_bit), 0);
        tx_bit = 1; cycles(2);
        check("R8 wired loop high", int'(rx_bit), 1);
        sir_en = 1; tx_bit = 0; cycles(2);
        check("R8 wired loop sees marking", int'(rx_bit), 1);
        check("R4 txd held high", int'(uart_txd), 1);
        tx_bit = 1; sir_en = 0; loop_en = 0; cycles(4);

        // R4: wired rx ignored while active
        sir_en = 1; uart_rxd = 0; cycles(80);
        check("R4 uart_rxd ignored", int'(rx_bit), 1);

        // R5: single external pulse, then a sub-tick glitch
        nl0 = n_low;
        wait_strobe(); sir_in_n = 0; wait_strobe(); sir_in_n = 1;
        strobes(30);
        check("R5 one low run", n_low - nl0, 1);
        check("R5 low run length", last_lo, 16 * div);
        nl0 = n_low;
        wait_strobe(); sir_in_n = 0; @(negedge clk); sir_in_n = 1;
        strobes(20);
        check("R5 glitch ignored", n_low - nl0, 0);
        check("R5 rx high after glitch", int'(rx_bit), 1);

        // R6: two back-to-back external pulses
        nl0 = n_low;
        wait_strobe(); sir_in_n = 0; wait_strobe(); sir_in_n = 1;
        strobes(14); sir_in_n = 0; strobes(2); sir_in_n = 1;
        strobes(30);
        check("R6 merged low run", n_low - nl0, 1);
        check("R6 merged length", last_lo, 32 * div);
        sir_en = 0; uart_rxd = 1; cycles(4);

        // R1 R2 R7 sweep
        for (int m = 0; m < 2; m++)
            for (int dd = 0; dd < 2; dd++)
                for (int p = 0; p < 16; p++)
                    run_pattern(m[0], (dd == 0) ? 4 : 8, p[3:0]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule